// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the sequencing state machine for a 32-bit load/store processor that runs one instruction over several clock cycles and reaches instructions and data through a single memory port. It watches the opcode and function fields held in the instruction register and the equality flag from the operand comparator. Each cycle it drives every enable and multiplexer select that the datapath needs: program-counter update, instruction capture, memory read or write and the address source, the loads of the operand, result and memory-data registers, the ALU operand selects and operation, and the register-file write controls.

Every instruction starts with a fetch state and a decode state. From decode the machine branches into a short path of its own for loads, stores, register-register arithmetic, immediate addition, branch-if-equal, absolute jump or jump through a register. Each path ends by going back to fetch. During fetch the program counter steps by 4 on a dedicated incrementer. During decode the ALU computes the branch target ahead of time, while the operand registers are loaded.

The control outputs are decoded from the registered state alone. The one exception is the program-counter write in the branch state, which also follows the equality flag. The state number is also brought out for observation.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low the state is 0 (fetch) and the outputs carry the fetch pattern. The first rising clock edge after release moves the machine to state 1.
- R2: In state 0, `ir_we`, `mem_rd` and `pc_we` are 1, `pc_src`=0 (incrementer) and `mem_addr_sel`=0 (PC). The next state is 1.
- R3: In state 1, `a_ld`, `b_ld` and `aluout_ld` are 1, `alu_a_sel`=0 (PC), `alu_b_sel`=2 (offset shifted left by two) and `alu_op`=0 (add).
- R4: From state 1 the next state follows the opcode: 000010 (jump) goes to 9; 000100 (branch-equal) goes to 8; 000000 with function 100000 goes to 11; 000000 with a known arithmetic function goes to 6; 100011 or 101011 (load or store) goes to 2; 001000 (add-immediate) goes to 10.
- R5: For a load, state 2 sets `alu_a_sel`=1 (A), `alu_b_sel`=1 (offset), `alu_op`=0 and `aluout_ld`. State 3 sets `mem_rd`, `mem_addr_sel`=1 (ALUout) and `mdr_ld`. State 4 sets `rf_we`, `rf_wsel`=0 (rt) and `rf_dsel`=1 (memory data). The sequence is 2, 3, 4, 0.
- R6: For a store (opcode 101011) state 2 goes to state 5. State 5 sets `mem_wr` and `mem_addr_sel`=1, then returns to 0.
- R7: State 6 sets `alu_a_sel`=1, `alu_b_sel`=0 (B) and `aluout_ld`. `alu_op` comes from the function field: 000000→0 add, 010010→1 sub, 000100→2 and, 010101→3 or, 011010→4 set-less-than. State 7 sets `rf_we`, `rf_wsel`=1 (rd) and `rf_dsel`=0, then returns to 0.
- R8: In state 8, `pc_src`=1 (ALUout) and `pc_we` equals `a_eq_b`. The next state is 0 whatever the flag.
- R9: State 9 sets `pc_we` with `pc_src`=2 (upper PC bits joined to the address field). State 11 sets `pc_we` with `pc_src`=3 (register A). Both return to 0.
- R10: State 10 sets `alu_a_sel`=1, `alu_b_sel`=1, `alu_op`=0 and `aluout_ld`. State 12 sets `rf_we`, `rf_wsel`=0 and `rf_dsel`=0, then returns to 0.
- R11: `mem_rd` and `mem_wr` are never 1 in the same cycle.
- R12: An unlisted opcode, or opcode 000000 with an unlisted function, makes state 1 go straight to 0, so that instruction raises no `pc_we`, `rf_we` or `mem_wr` before the next fetch.
- R13: Every control output not named for the current state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| a_eq_b | input | 1 | Operand registers A and B are equal |
| pc_we | output | 1 | Program counter write |
| pc_src | output | 2 | PC source: 0 incrementer, 1 ALUout, 2 jump target, 3 A |
| ir_we | output | 1 | Instruction register load |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALUout |
| a_ld | output | 1 | Load register A from rs |
| b_ld | output | 1 | Load register B from rt |
| aluout_ld | output | 1 | Load ALU result register |
| mdr_ld | output | 1 | Load memory data register |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 A |
| alu_b_sel | output | 2 | ALU operand B: 0 B, 1 offset, 2 offset shifted by two |
| alu_op | output | 3 | 0 add, 1 sub, 2 and, 3 or, 4 set-less-than |
| rf_we | output | 1 | Register file write |
| rf_wsel | output | 1 | Write register: 0 rt, 1 rd |
| rf_dsel | output | 1 | Write data: 0 ALUout, 1 memory data |
| state | output | 4 | Current state number |

## Verification
The outputs are decoded from the state register, so they change within the same cycle as the state. The state itself moves one rising edge after the opcode, function and flag values it is computed from. The one output that follows an input directly is `pc_we` in state 8, which tracks `a_eq_b` within the cycle. The bench sets the inputs on the falling edge and compares outputs and state a nanosecond later against a reference state. It then advances that reference state by one step for the next rising edge. The opcode and function stay fixed for a whole instruction, as an instruction register would hold them, and change only while the machine is in fetch.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int ST_W  = 4;
    localparam int AOP_W = 3;

    typedef enum logic [ST_W-1:0] {
        S_FETCH  = 4'd0,
        S_DECODE = 4'd1,
        S_MADDR  = 4'd2,
        S_MREAD  = 4'd3,
        S_LWB    = 4'd4,
        S_MWRITE = 4'd5,
        S_REXE   = 4'd6,
        S_RWB    = 4'd7,
        S_BRANCH = 4'd8,
        S_JUMP   = 4'd9,
        S_IEXE   = 4'd10,
        S_JREG   = 4'd11,
        S_IWB    = 4'd12
    } state_e;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'b001000;

    localparam logic [FN_W-1:0] FN_ADD = 6'b000000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b010010;
    localparam logic [FN_W-1:0] FN_AND = 6'b000100;
    localparam logic [FN_W-1:0] FN_OR  = 6'b010101;
    localparam logic [FN_W-1:0] FN_SLT = 6'b011010;
    localparam logic [FN_W-1:0] FN_JR  = 6'b100000;

    localparam logic [AOP_W-1:0] AOP_ADD = 3'd0;
    localparam logic [AOP_W-1:0] AOP_SUB = 3'd1;
    localparam logic [AOP_W-1:0] AOP_AND = 3'd2;
    localparam logic [AOP_W-1:0] AOP_OR  = 3'd3;
    localparam logic [AOP_W-1:0] AOP_SLT = 3'd4;

    localparam logic [1:0] PCS_INC  = 2'd0;
    localparam logic [1:0] PCS_ALU  = 2'd1;
    localparam logic [1:0] PCS_JMP  = 2'd2;
    localparam logic [1:0] PCS_REGA = 2'd3;

    localparam logic [1:0] BSEL_B    = 2'd0;
    localparam logic [1:0] BSEL_IMM  = 2'd1;
    localparam logic [1:0] BSEL_IMM4 = 2'd2;

    typedef struct packed {
        logic             pc_we;
        logic [1:0]       pc_src;
        logic             ir_we;
        logic             mem_rd;
        logic             mem_wr;
        logic             mem_addr_sel;
        logic             a_ld;
        logic             b_ld;
        logic             aluout_ld;
        logic             mdr_ld;
        logic             alu_a_sel;
        logic [1:0]       alu_b_sel;
        logic [AOP_W-1:0] alu_op;
        logic             rf_we;
        logic             rf_wsel;
        logic             rf_dsel;
    } ctrl_t;

endpackage

// File: rtl/mc_funct_dec.sv
module mc_funct_dec
    import mc_ctrl_pkg::*;
(
    input  logic [FN_W-1:0]  funct,
    output logic [AOP_W-1:0] arith_op,
    output logic             arith_ok,
    output logic             is_jreg
);
    always_comb begin
        arith_op = AOP_ADD;
        arith_ok = 1'b1;
        is_jreg  = 1'b0;
        unique case (funct)
            FN_ADD:  arith_op = AOP_ADD;
            FN_SUB:  arith_op = AOP_SUB;
            FN_AND:  arith_op = AOP_AND;
            FN_OR:   arith_op = AOP_OR;
            FN_SLT:  arith_op = AOP_SLT;
            FN_JR: begin
                arith_ok = 1'b0;
                is_jreg  = 1'b1;
            end
            default: arith_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/mc_dispatch.sv
module mc_dispatch
    import mc_ctrl_pkg::*;
(
    input  state_e          cur,
    input  logic [OP_W-1:0] opcode,
    input  logic            arith_ok,
    input  logic            is_jreg,
    output state_e          nxt
);
    state_e from_decode;

    always_comb begin
        unique case (opcode)
            OPC_JUMP:             from_decode = S_JUMP;
            OPC_BEQ:              from_decode = S_BRANCH;
            OPC_LOAD, OPC_STORE:  from_decode = S_MADDR;
            OPC_ADDI:             from_decode = S_IEXE;
            OPC_RTYPE: begin
                if (is_jreg)       from_decode = S_JREG;
                else if (arith_ok) from_decode = S_REXE;
                else               from_decode = S_FETCH;
            end
            default:              from_decode = S_FETCH;
        endcase
    end

    always_comb begin
        unique case (cur)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: nxt = from_decode;
            S_MADDR:  nxt = (opcode == OPC_STORE) ? S_MWRITE : S_MREAD;
            S_MREAD:  nxt = S_LWB;
            S_REXE:   nxt = S_RWB;
            S_IEXE:   nxt = S_IWB;
            default:  nxt = S_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
    import mc_ctrl_pkg::*;
(
    input  state_e           cur,
    input  logic             a_eq_b,
    input  logic [AOP_W-1:0] arith_op,
    output ctrl_t            ctl
);
    always_comb begin
        ctl = '0;
        unique case (cur)
            S_FETCH: begin
                ctl.ir_we  = 1'b1;
                ctl.mem_rd = 1'b1;
                ctl.pc_we  = 1'b1;
                ctl.pc_src = PCS_INC;
            end
            S_DECODE: begin
                ctl.a_ld      = 1'b1;
                ctl.b_ld      = 1'b1;
                ctl.aluout_ld = 1'b1;
                ctl.alu_b_sel = BSEL_IMM4;
                ctl.alu_op    = AOP_ADD;
            end
            S_MADDR, S_IEXE: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_IMM;
                ctl.alu_op    = AOP_ADD;
                ctl.aluout_ld = 1'b1;
            end
            S_MREAD: begin
                ctl.mem_rd       = 1'b1;
                ctl.mem_addr_sel = 1'b1;
                ctl.mdr_ld       = 1'b1;
            end
            S_LWB: begin
                ctl.rf_we   = 1'b1;
                ctl.rf_dsel = 1'b1;
            end
            S_MWRITE: begin
                ctl.mem_wr       = 1'b1;
                ctl.mem_addr_sel = 1'b1;
            end
            S_REXE: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_B;
                ctl.alu_op    = arith_op;
                ctl.aluout_ld = 1'b1;
            end
            S_RWB: begin
                ctl.rf_we   = 1'b1;
                ctl.rf_wsel = 1'b1;
            end
            S_IWB: ctl.rf_we = 1'b1;
            S_BRANCH: begin
                ctl.pc_src = PCS_ALU;
                ctl.pc_we  = a_eq_b;
            end
            S_JUMP: begin
                ctl.pc_we  = 1'b1;
                ctl.pc_src = PCS_JMP;
            end
            S_JREG: begin
                ctl.pc_we  = 1'b1;
                ctl.pc_src = PCS_REGA;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int OPCODE_W = OP_W,
    parameter int FUNCT_W  = FN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OPCODE_W-1:0] opcode,
    input  logic [FUNCT_W-1:0]  funct,
    input  logic                a_eq_b,
    output logic                pc_we,
    output logic [1:0]          pc_src,
    output logic                ir_we,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic                mem_addr_sel,
    output logic                a_ld,
    output logic                b_ld,
    output logic                aluout_ld,
    output logic                mdr_ld,
    output logic                alu_a_sel,
    output logic [1:0]          alu_b_sel,
    output logic [AOP_W-1:0]    alu_op,
    output logic                rf_we,
    output logic                rf_wsel,
    output logic                rf_dsel,
    output logic [ST_W-1:0]     state
);
    typedef struct packed {
        state_e st;
    } seq_t;

    seq_t             seq_d, seq_q;
    state_e           disp_nxt;
    logic [AOP_W-1:0] arith_op;
    logic             arith_ok;
    logic             is_jreg;
    ctrl_t            ctl;

    mc_funct_dec i_fdec (
        .funct    (funct[FN_W-1:0]),
        .arith_op (arith_op),
        .arith_ok (arith_ok),
        .is_jreg  (is_jreg)
    );

    mc_dispatch i_disp (
        .cur      (seq_q.st),
        .opcode   (opcode[OP_W-1:0]),
        .arith_ok (arith_ok),
        .is_jreg  (is_jreg),
        .nxt      (disp_nxt)
    );

    mc_ctrl_out i_out (
        .cur      (seq_q.st),
        .a_eq_b   (a_eq_b),
        .arith_op (arith_op),
        .ctl      (ctl)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.st = disp_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: S_FETCH};
        else        seq_q <= seq_d;
    end

    assign pc_we        = ctl.pc_we;
    assign pc_src       = ctl.pc_src;
    assign ir_we        = ctl.ir_we;
    assign mem_rd       = ctl.mem_rd;
    assign mem_wr       = ctl.mem_wr;
    assign mem_addr_sel = ctl.mem_addr_sel;
    assign a_ld         = ctl.a_ld;
    assign b_ld         = ctl.b_ld;
    assign aluout_ld    = ctl.aluout_ld;
    assign mdr_ld       = ctl.mdr_ld;
    assign alu_a_sel    = ctl.alu_a_sel;
    assign alu_b_sel    = ctl.alu_b_sel;
    assign alu_op       = ctl.alu_op;
    assign rf_we        = ctl.rf_we;
    assign rf_wsel      = ctl.rf_wsel;
    assign rf_dsel      = ctl.rf_dsel;
    assign state        = seq_q.st;

    // R11: one memory port, never read and write together
    a_r11_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2: fetch is always followed by decode
    a_r2_fetch_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'd0) |=> (state == 4'd1));

    // R5: memory read always followed by load write-back
    a_r5_read_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'd3) |=> (state == 4'd4));

    // R8: a not-taken branch leaves the PC alone
    a_r8_branch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'd8 && !a_eq_b) |-> !pc_we);

    // R9: terminal states return to fetch
    a_r9_back_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 4'd9 || state == 4'd11 || state == 4'd8 || state == 4'd12)
        |=> (state == 4'd0));

    // R12: at most one architectural writer per cycle
    a_r12_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pc_we, rf_we, mem_wr}) <= 1);
endmodule

// File: tb/test_mc_ctrl_fsm.sv
module test_mc_ctrl_fsm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic       a_eq_b = 1'b0;
    logic       pc_we, ir_we, mem_rd, mem_wr, mem_addr_sel;
    logic       a_ld, b_ld, aluout_ld, mdr_ld, alu_a_sel;
    logic       rf_we, rf_wsel, rf_dsel;
    logic [1:0] pc_src, alu_b_sel;
    logic [2:0] alu_op;
    logic [3:0] state;

    int checks = 0;
    int failures = 0;
    int ref_st = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mc_ctrl_fsm i_mc_ctrl_fsm (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .a_eq_b(a_eq_b),
        .pc_we(pc_we), .pc_src(pc_src), .ir_we(ir_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr_sel(mem_addr_sel), .a_ld(a_ld), .b_ld(b_ld), .aluout_ld(aluout_ld),
        .mdr_ld(mdr_ld), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
        .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_dsel(rf_dsel), .state(state)
    );

    function automatic int fn_op(input logic [5:0] fn);
        case (fn)
            6'b000000: return 0;
            6'b010010: return 1;
            6'b000100: return 2;
            6'b010101: return 3;
            6'b011010: return 4;
            default:   return -1;
        endcase
    endfunction

    function automatic int exp_next(input int st, input logic [5:0] op, input logic [5:0] fn);
        case (st)
            0: return 1;
            1: case (op)
                   6'b000010: return 9;
                   6'b000100: return 8;
                   6'b100011, 6'b101011: return 2;
                   6'b001000: return 10;
                   6'b000000: begin
                       if (fn == 6'b100000) return 11;
                       if (fn_op(fn) >= 0) return 6;
                       return 0;
                   end
                   default: return 0;
               endcase
            2: return (op == 6'b101011) ? 5 : 3;
            3: return 4;
            6: return 7;
            10: return 12;
            default: return 0;
        endcase
    endfunction

    // packing: pc_we pc_src ir_we mem_rd mem_wr mem_addr_sel a_ld b_ld aluout_ld mdr_ld
    //          alu_a_sel alu_b_sel alu_op rf_we rf_wsel rf_dsel
    function automatic logic [19:0] pack(input logic pw, input logic [1:0] ps, input logic ir,
        input logic mr, input logic mw, input logic ma, input logic al, input logic bl,
        input logic ol, input logic dl, input logic as, input logic [1:0] bs,
        input logic [2:0] ao, input logic rw, input logic ws, input logic ds);
        return {pw, ps, ir, mr, mw, ma, al, bl, ol, dl, as, bs, ao, rw, ws, ds};
    endfunction

    function automatic logic [19:0] exp_ctrl(input int st, input logic eq, input logic [5:0] fn);
        case (st)
            0:  return pack(1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            1:  return pack(0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 2, 0, 0, 0, 0);
            2, 10: return pack(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0, 0);
            3:  return pack(0, 0, 0, 1, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
            4:  return pack(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
            5:  return pack(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            6:  return pack(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 3'(fn_op(fn)), 0, 0, 0);
            7:  return pack(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
            8:  return pack(eq, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            9:  return pack(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            11: return pack(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            12: return pack(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input int st);
        case (st)
            0: return "R2";
            1: return "R3";
            2, 3, 4: return "R5";
            5: return "R6";
            6, 7: return "R7";
            8: return "R8";
            9, 11: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [19:0] dut_ctrl();
        return {pc_we, pc_src, ir_we, mem_rd, mem_wr, mem_addr_sel, a_ld, b_ld, aluout_ld,
                mdr_ld, alu_a_sel, alu_b_sel, alu_op, rf_we, rf_wsel, rf_dsel};
    endfunction

    task automatic check_now(input string tag);
        logic [19:0] e;
        e = exp_ctrl(ref_st, a_eq_b, funct);
        checks++;
        if (dut_ctrl() !== e) begin
            failures++;
            $display("FAIL %s/R13 state %0d ctrl actual=%b expected=%b", tag, ref_st, dut_ctrl(), e);
        end
        checks++;
        if (state !== 4'(ref_st)) begin
            failures++;
            $display("FAIL R4/R12 state actual=%0d expected=%0d", state, ref_st);
        end
        checks++;
        if (mem_rd && mem_wr) begin
            failures++;
            $display("FAIL R11 mem_rd/mem_wr actual=11 expected=not both");
        end
    endtask

    // called one ns after a falling edge; leaves time at the next falling edge
    task automatic step(input string tag);
        int prev;
        check_now(tag);
        prev = ref_st;
        ref_st = exp_next(ref_st, opcode, funct);
        if (prev == 1 && ref_st == 0) begin
            // R12: decode aborted, nothing written before refetch
            checks++;
            if (pc_we || rf_we || mem_wr) begin
                failures++;
                $display("FAIL R12 writes actual=%b%b%b expected=000", pc_we, rf_we, mem_wr);
            end
        end
        @(negedge clk);
        #1;
    endtask

    task automatic run_instr(input logic [5:0] op, input logic [5:0] fn, input logic eq);
        opcode = op;
        funct  = fn;
        a_eq_b = eq;
        #0;
        do step(tag_of(ref_st)); while (ref_st != 0);
    endtask

    function automatic logic [5:0] pick_op(input int unsigned r);
        case (r % 9)
            0: return 6'b100011;
            1: return 6'b101011;
            2: return 6'b000100;
            3: return 6'b000000;
            4: return 6'b000010;
            5: return 6'b001000;
            6: return 6'b000000;
            7: return 6'b000000;
            default: return 6'($urandom);
        endcase
    endfunction

    function automatic logic [5:0] pick_fn(input int unsigned r);
        case (r % 8)
            0: return 6'b000000;
            1: return 6'b010010;
            2: return 6'b000100;
            3: return 6'b010101;
            4: return 6'b011010;
            5: return 6'b100000;
            default: return 6'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state and fetch outputs while held in reset
        ref_st = 0;
        check_now("R1");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_now("R1");
        // directed: R5 load, R6 store, R7 each function, R8 both flags, R9, R10, R12
        run_instr(6'b100011, 6'b000000, 1'b0);
        run_instr(6'b101011, 6'b000000, 1'b0);
        run_instr(6'b000000, 6'b000000, 1'b0);
        run_instr(6'b000000, 6'b010010, 1'b0);
        run_instr(6'b000000, 6'b000100, 1'b0);
        run_instr(6'b000000, 6'b010101, 1'b0);
        run_instr(6'b000000, 6'b011010, 1'b0);
        run_instr(6'b000100, 6'b000000, 1'b1);
        run_instr(6'b000100, 6'b000000, 1'b0);
        run_instr(6'b000010, 6'b000000, 1'b0);
        run_instr(6'b000000, 6'b100000, 1'b0);
        run_instr(6'b001000, 6'b000000, 1'b0);
        run_instr(6'b111111, 6'b000000, 1'b0);
        run_instr(6'b000000, 6'b111111, 1'b0);
        run_instr(6'b000011, 6'b000000, 1'b1);
        for (int i = 0; i < 3000; i++) begin
            run_instr(pick_op($urandom), pick_fn($urandom), 1'($urandom));
        end
        // R1: reset in mid-instruction returns to fetch
        run_instr(6'b100011, 6'b000000, 1'b0);
        step("R2");
        step("R3");
        rst_n = 1'b0;
        #1;
        ref_st = 0;
        check_now("R1");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule